// File: doc/BRIEF.md
# Host Bridge Address Window Translator

This block sits between a processor's load/store port and a PCI host bridge. Each processor request is matched against three address windows. A hit becomes a rewritten request on a downstream port: either a configuration cycle, an I/O cycle or a memory cycle. The configuration window turns a one-hot device-select field into a compact numbered configuration address. The I/O window folds the processor offset into a 16-bit port number. A level-sensitive mode pin picks one of two ways to fold it: a plain contiguous 64 KB space, or a sparse layout that places groups of 32 ports on separate 4 KB pages across 8 MB.

Accesses are 1, 2 or 4 bytes wide and may be unaligned. The downstream data path is eight byte lanes wide and little-endian, with a word-aligned address. Because of this, an access that crosses a 32-bit boundary still goes out as a single request. An address that hits no window gets an immediate error response.

A second, independent port translates addresses that PCI agents issue as bus masters. Low addresses go to PCI memory and high addresses go to system memory.

Top module: `hb_xlate`

## Requirements
- R1: Processor addresses 0x8080_0000 to 0x80BF_FFFF go out with `dn_kind` 0 (configuration). Addresses 0x8000_0000 to 0x807F_FFFF go out with kind 1 (I/O). Addresses 0xC000_0000 to 0xFEFF_FFFF go out with kind 2 (memory), and the downstream address is the processor address minus 0xC000_0000.
- R2: For a configuration hit, address bits 11 to 21 are searched from bit 11 upward. The position of the lowest set bit, 0 to 10, is placed in `dn_addr` from bit 11 upward. Address bits 10:2 are copied unchanged.
- R3: A configuration hit with none of bits 11 to 21 set places the value 11 in `dn_addr` from bit 11 upward.
- R4: With `io_sparse` at 0, the I/O port is the low 16 bits of (address minus 0x8000_0000).
- R5: With `io_sparse` at 1, the I/O port is formed from the offset (address minus 0x8000_0000). Offset bits 22:12 become port bits 15:5, and offset bits 4:0 become port bits 4:0. Offset bits 11:5 are discarded.
- R6: `io_sparse` is sampled only when a request is accepted. Changing it while a request is outstanding does not alter that request.
- R7: `dn_addr` bits 1:0 are always zero. Let `cpu_size` be 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Then `dn_be` equals the size mask shifted left by the translated address bits 1:0. `dn_wdata` holds the write data with unused bytes cleared, shifted left by eight times those bits.
- R8: Read response data is `dn_rdata` shifted right by eight times the translated address bits 1:0, then trimmed to the access size with the upper bytes at zero.
- R9: A request that hits no window creates no downstream request. On the cycle after acceptance it returns `rsp_valid` with `rsp_err` at 1 and read data of all ones. `rsp_err` is high for that single cycle.
- R10: A request is accepted when `cpu_valid` and `cpu_ready` are both high. The downstream request appears on the following cycle and holds steady until `dn_ready`. `cpu_ready` stays low from acceptance until the cycle after the response.
- R11: Bus-master addresses below 0x3F00_0000 appear one cycle later with `bm_out_tgt` 1 and the address unchanged. Addresses from 0x3F00_0000 to 0x7FFF_FFFF give `bm_out_tgt` 0 and address 0.
- R12: Bus-master addresses at or above 0x8000_0000 appear one cycle later with `bm_out_tgt` 2 and the address minus 0x8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sparse | input | 1 | I/O layout select: 0 contiguous, 1 sparse |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_we | input | 1 | Request is a write |
| cpu_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2/3 four bytes |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_err | output | 1 | Response for an unmapped address |
| rsp_rdata | output | 32 | Read data, right-aligned |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream takes the request |
| dn_kind | output | 2 | 0 configuration, 1 I/O, 2 memory |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Translated word-aligned address |
| dn_be | output | 8 | Byte-lane enables |
| dn_wdata | output | 64 | Lane-steered write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 64 | Downstream read lanes, valid with dn_ack |
| bm_valid | input | 1 | Bus-master address valid |
| bm_addr | input | 32 | Bus-master PCI address |
| bm_out_valid | output | 1 | Translated bus-master address valid |
| bm_out_tgt | output | 2 | 0 unmapped, 1 PCI memory, 2 system memory |
| bm_out_addr | output | 32 | Translated bus-master address |

## Verification
The bench covers the following corner cases:
- Configuration addresses with two select bits set, with only the top select bit set, and with none set. An encoder that searched from the top, or that left the empty case at zero, would produce the wrong device number.
- The same I/O offset issued in both modes. A sparse fold that kept offset bits 11:5, or shifted by the wrong amount, would give the wrong port.
- The mode pin toggled while a stalled request waits. A design that decoded late would change that request's address.
- Four-byte accesses at byte offset 3 and two-byte accesses at odd offsets. A design that clipped lanes at the word edge, or did not shift read data back down, would return bytes from the wrong lanes.
- Addresses just outside each window and on both sides of the bus-master split. A design with an off-by-one bound would hit where it should miss, or the reverse.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int NLANE     = 8;
    localparam int LDW       = NLANE * 8;
    localparam int SEL_LSB   = 11;
    localparam int SEL_BITS  = 11;
    localparam int IDX_W     = $clog2(SEL_BITS + 1);
    localparam int PORT_W    = 16;
    localparam int SP_KEEP   = 5;
    localparam int SP_PAGE   = 12;
    localparam int SP_PGBITS = PORT_W - SP_KEEP;

    localparam logic [AW-1:0] CFG_BASE  = 32'h8080_0000;
    localparam logic [AW-1:0] CFG_SPAN  = 32'h0040_0000;
    localparam logic [AW-1:0] IO_BASE   = 32'h8000_0000;
    localparam logic [AW-1:0] IO_SPAN   = 32'h0080_0000;
    localparam logic [AW-1:0] MEM_BASE  = 32'hC000_0000;
    localparam logic [AW-1:0] MEM_SPAN  = 32'h3F00_0000;
    localparam logic [AW-1:0] BM_SPLIT  = 32'h8000_0000;

    typedef enum logic [1:0] {
        KIND_CFG = 2'd0,
        KIND_IO  = 2'd1,
        KIND_MEM = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        BM_NONE   = 2'd0,
        BM_PCIMEM = 2'd1,
        BM_SYSMEM = 2'd2
    } bm_tgt_e;

    typedef struct packed {
        logic          hit;
        kind_e         kind;
        logic [AW-1:0] addr;
    } xlate_t;

    function automatic logic in_window(logic [AW-1:0] a, logic [AW-1:0] base,
                                       logic [AW-1:0] span);
        return (a >= base) && ((a - base) < span);
    endfunction

    function automatic logic [3:0] size_mask(logic [1:0] size);
        case (size)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] byte_expand(logic [3:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    function automatic logic [AW-1:0] sparse_fold(logic [AW-1:0] off);
        logic [AW-1:0] r;
        r = '0;
        r[SP_KEEP-1:0]          = off[SP_KEEP-1:0];
        r[SP_KEEP +: SP_PGBITS] = off[SP_PAGE +: SP_PGBITS];
        return r;
    endfunction

endpackage

// File: rtl/hbx_cfg_encode.sv
module hbx_cfg_encode #(
    parameter int SEL_BITS = 11,
    parameter int IDX_W    = $clog2(SEL_BITS + 1)
) (
    input  logic [SEL_BITS-1:0] sel,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        idx = IDX_W'(SEL_BITS);
        for (int i = SEL_BITS - 1; i >= 0; i--) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/hbx_decode.sv
module hbx_decode
    import hbx_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          sparse,
    output xlate_t        xo
);
    logic [IDX_W-1:0] dev_idx;
    logic [AW-1:0]    io_off;

    hbx_cfg_encode #(.SEL_BITS(SEL_BITS), .IDX_W(IDX_W)) u_enc (
        .sel (addr[SEL_LSB +: SEL_BITS]),
        .idx (dev_idx)
    );

    assign io_off = addr - IO_BASE;

    always_comb begin
        xo.hit  = 1'b0;
        xo.kind = KIND_MEM;
        xo.addr = '0;
        if (in_window(addr, CFG_BASE, CFG_SPAN)) begin
            xo.hit  = 1'b1;
            xo.kind = KIND_CFG;
            xo.addr = (AW'(dev_idx) << SEL_LSB) | AW'(addr[SEL_LSB-1:0]);
        end else if (in_window(addr, IO_BASE, IO_SPAN)) begin
            xo.hit  = 1'b1;
            xo.kind = KIND_IO;
            xo.addr = sparse ? sparse_fold(io_off) : AW'(io_off[PORT_W-1:0]);
        end else if (in_window(addr, MEM_BASE, MEM_SPAN)) begin
            xo.hit  = 1'b1;
            xo.kind = KIND_MEM;
            xo.addr = addr - MEM_BASE;
        end
    end
endmodule

// File: rtl/hbx_lanes.sv
module hbx_lanes
    import hbx_pkg::*;
(
    input  logic [1:0]       req_size,
    input  logic [1:0]       req_off,
    input  logic [DW-1:0]    req_wdata,
    output logic [NLANE-1:0] req_be,
    output logic [LDW-1:0]   req_lanes,
    input  logic [1:0]       rsp_size,
    input  logic [1:0]       rsp_off,
    input  logic [LDW-1:0]   rsp_lanes,
    output logic [DW-1:0]    rsp_data
);
    logic [3:0] wmask, rmask;
    logic       unused_top;

    assign wmask     = size_mask(req_size);
    assign rmask     = size_mask(rsp_size);
    assign req_be    = NLANE'({4'b0000, wmask}) << req_off;
    assign req_lanes = LDW'(req_wdata & byte_expand(wmask)) << {req_off, 3'b000};
    assign rsp_data  = rsp_lanes[{rsp_off, 3'b000} +: DW] & byte_expand(rmask);
    assign unused_top = ^rsp_lanes[LDW-1:LDW-8];
endmodule

// File: rtl/hbx_bm.sv
module hbx_bm
    import hbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bm_valid,
    input  logic [AW-1:0] bm_addr,
    output logic          out_valid,
    output bm_tgt_e       out_tgt,
    output logic [AW-1:0] out_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tgt   <= BM_NONE;
            out_addr  <= '0;
        end else begin
            out_valid <= bm_valid;
            if (bm_valid) begin
                if (bm_addr >= BM_SPLIT) begin
                    out_tgt  <= BM_SYSMEM;
                    out_addr <= bm_addr - BM_SPLIT;
                end else if (bm_addr < MEM_SPAN) begin
                    out_tgt  <= BM_PCIMEM;
                    out_addr <= bm_addr;
                end else begin
                    out_tgt  <= BM_NONE;
                    out_addr <= '0;
                end
            end
        end
    end

    AST_BM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bm_valid |=> out_valid);                                          // R11
    AST_BM_PCI_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_tgt == BM_PCIMEM |-> out_addr < MEM_SPAN);       // R11
endmodule

// File: rtl/hb_xlate.sv
module hb_xlate
    import hbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_sparse,
    input  logic             cpu_valid,
    output logic             cpu_ready,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_size,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [1:0]       dn_kind,
    output logic             dn_we,
    output logic [AW-1:0]    dn_addr,
    output logic [NLANE-1:0] dn_be,
    output logic [LDW-1:0]   dn_wdata,
    input  logic             dn_ack,
    input  logic [LDW-1:0]   dn_rdata,
    input  logic             bm_valid,
    input  logic [AW-1:0]    bm_addr,
    output logic             bm_out_valid,
    output logic [1:0]       bm_out_tgt,
    output logic [AW-1:0]    bm_out_addr
);
    typedef enum logic {ST_IDLE, ST_WAIT} state_e;

    state_e           state;
    xlate_t           xl;
    kind_e            kind_q;
    bm_tgt_e          bm_tgt;
    logic [1:0]       off_q, size_q;
    logic [NLANE-1:0] be_n;
    logic [LDW-1:0]   lanes_n;
    logic [DW-1:0]    rd_steer;
    logic             accept;

    hbx_decode u_dec (.addr(cpu_addr), .sparse(io_sparse), .xo(xl));

    hbx_lanes u_lanes (
        .req_size (cpu_size),  .req_off (xl.addr[1:0]), .req_wdata (cpu_wdata),
        .req_be   (be_n),      .req_lanes (lanes_n),
        .rsp_size (size_q),    .rsp_off (off_q),        .rsp_lanes (dn_rdata),
        .rsp_data (rd_steer)
    );

    hbx_bm u_bm (
        .clk (clk), .rst (rst), .bm_valid (bm_valid), .bm_addr (bm_addr),
        .out_valid (bm_out_valid), .out_tgt (bm_tgt), .out_addr (bm_out_addr)
    );

    assign bm_out_tgt = bm_tgt;
    assign dn_kind    = kind_q;
    assign cpu_ready  = (state == ST_IDLE) && !rsp_valid;
    assign accept     = cpu_valid && cpu_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dn_valid  <= 1'b0;
            kind_q    <= KIND_CFG;
            dn_we     <= 1'b0;
            dn_addr   <= '0;
            dn_be     <= '0;
            dn_wdata  <= '0;
            off_q     <= '0;
            size_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (xl.hit) begin
                        state    <= ST_WAIT;
                        dn_valid <= 1'b1;
                        kind_q   <= xl.kind;
                        dn_we    <= cpu_we;
                        dn_addr  <= {xl.addr[AW-1:2], 2'b00};
                        dn_be    <= be_n;
                        dn_wdata <= lanes_n;
                        off_q    <= xl.addr[1:0];
                        size_q   <= cpu_size;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '1;
                    end
                end
                ST_WAIT: begin
                    if (dn_valid) begin
                        if (dn_ready) dn_valid <= 1'b0;
                    end else if (dn_ack) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= dn_we ? '0 : rd_steer;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !cpu_ready);                                         // R10
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be)); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> !rsp_err);                                            // R9
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid && rsp_rdata == '1);                        // R9
    AST_MISS_NO_DN: assert property (@(posedge clk) disable iff (rst)
        accept && !xl.hit |=> !dn_valid);                                 // R9
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> ($countones(dn_be) == 1 || $countones(dn_be) == 2
                      || $countones(dn_be) == 4));                        // R7
endmodule

// File: tb/hb_xlate_test.sv
`timescale 1ns/1ps
module hb_xlate_test;
    logic        clk = 0, rst = 1, io_sparse = 0;
    logic        cpu_valid = 0, cpu_we = 0;
    logic [1:0]  cpu_size = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic        cpu_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_valid, dn_ready = 1, dn_we, dn_ack = 0;
    logic [1:0]  dn_kind;
    logic [31:0] dn_addr;
    logic [7:0]  dn_be;
    logic [63:0] dn_wdata, dn_rdata = 0;
    logic        bm_valid = 0, bm_out_valid;
    logic [31:0] bm_addr = 0, bm_out_addr;
    logic [1:0]  bm_out_tgt;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    hb_xlate uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Shared access driver: hit requests go through the downstream model.
    task automatic access(input string req, input logic [31:0] a, input bit we,
                          input logic [1:0] sz, input logic [31:0] wd, input bit mode,
                          input bit hit, input logic [1:0] kind, input logic [31:0] ea,
                          input logic [7:0] ebe, input logic [63:0] ewd,
                          input logic [63:0] rpat, input logic [31:0] erd, input int stall);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        io_sparse = mode; cpu_valid = 1; cpu_we = we; cpu_size = sz;
        cpu_addr = a; cpu_wdata = wd; dn_ready = (stall == 0);
        @(posedge clk); @(negedge clk);
        cpu_valid = 0;
        if (!hit) begin
            chk(rsp_valid && rsp_err, req, "miss response", {rsp_valid, rsp_err}, 2'b11);
            chk(rsp_rdata == 32'hFFFF_FFFF, req, "miss data", rsp_rdata, 32'hFFFF_FFFF);
            chk(!dn_valid, req, "no downstream on miss", dn_valid, 0);
            @(negedge clk);
            chk(!rsp_err, req, "error one cycle", rsp_err, 0);
            dn_ready = 1;
            return;
        end
        chk(dn_valid && !cpu_ready, "R10", "request issued", {dn_valid, cpu_ready}, 2'b10);
        chk(dn_kind == kind, "R1", "kind", dn_kind, kind);
        chk(dn_addr == ea, req, "address", dn_addr, ea);
        chk(dn_be == ebe, "R7", "byte enables", dn_be, ebe);
        if (we) chk(dn_wdata == ewd, "R7", "write lanes", dn_wdata, ewd);
        for (int i = 0; i < stall; i++) begin
            io_sparse = ~io_sparse;
            @(negedge clk);
            chk(dn_valid && dn_addr == ea, "R6", "held under stall", dn_addr, ea);
        end
        dn_ready = 1;
        @(negedge clk);
        chk(!dn_valid, "R10", "request dropped after handshake", dn_valid, 0);
        dn_rdata = rpat; dn_ack = 1;
        @(negedge clk);
        dn_ack = 0;
        chk(rsp_valid && !rsp_err, "R10", "response", {rsp_valid, rsp_err}, 2'b10);
        if (!we) chk(rsp_rdata == erd, "R8", "read data", rsp_rdata, erd);
    endtask

    task automatic bm_probe(input string req, input logic [31:0] a,
                            input logic [1:0] et, input logic [31:0] ea);
        @(negedge clk);
        bm_valid = 1; bm_addr = a;
        @(negedge clk);
        bm_valid = 0;
        chk(bm_out_valid && bm_out_tgt == et, req, "bm target", bm_out_tgt, et);
        chk(bm_out_addr == ea, req, "bm address", bm_out_addr, ea);
    endtask

    localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

    task automatic t_reset();
        chk(cpu_ready && !dn_valid && !rsp_valid && !bm_out_valid, "R10", "reset state",
            {cpu_ready, dn_valid, rsp_valid, bm_out_valid}, 4'b1000);
    endtask

    task automatic t_config();
        access("R2", 32'h8080_2024, 0, 2, 0, 0, 1, 0, 32'h0000_1024, 8'h0F, 0,
               64'h1122_3344_AABB_CCDD, 32'hAABB_CCDD, 0);
        access("R2", 32'h8081_2008, 0, 2, 0, 0, 1, 0, 32'h0000_1008, 8'h0F, 0, PAT, 32'h4433_2211, 0);
        access("R2", 32'h80A0_0000, 0, 2, 0, 0, 1, 0, 32'h0000_5000, 8'h0F, 0, PAT, 32'h4433_2211, 0);
        access("R3", 32'h8080_0104, 0, 2, 0, 0, 1, 0, 32'h0000_5904, 8'h0F, 0, PAT, 32'h4433_2211, 0);
    endtask

    task automatic t_io_modes();
        access("R4", 32'h8012_0CFB, 1, 0, 32'h0000_005A, 0, 1, 1, 32'h0000_0CF8, 8'h08,
               64'h0000_0000_5A00_0000, 0, 0, 0);
        access("R5", 32'h8012_0CFB, 1, 0, 32'h0000_005A, 1, 1, 1, 32'h0000_2418, 8'h08,
               64'h0000_0000_5A00_0000, 0, 0, 0);
        access("R6", 32'h8012_0CFB, 0, 0, 0, 1, 1, 1, 32'h0000_2418, 8'h08, 0, PAT, 32'h0000_0044, 3);
    endtask

    task automatic t_lanes();
        access("R8", 32'h8000_0003, 0, 2, 0, 0, 1, 1, 32'h0, 8'h78, 0, PAT, 32'h7766_5544, 0);
        access("R8", 32'hC000_1236, 0, 1, 0, 0, 1, 2, 32'h0000_1234, 8'h0C, 0, PAT, 32'h0000_4433, 0);
        access("R7", 32'hC000_0001, 1, 1, 32'hABCD_1234, 0, 1, 2, 32'h0, 8'h06,
               64'h0000_0000_0012_3400, 0, 0, 0);
        access("R1", 32'hFEFF_FFFC, 0, 2, 0, 0, 1, 2, 32'h3EFF_FFFC, 8'h0F, 0, PAT, 32'h4433_2211, 0);
    endtask

    task automatic t_miss();
        access("R9", 32'h9000_0000, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access("R9", 32'hFF00_0000, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access("R9", 32'h7FFF_FFFF, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access("R9", 32'h80C0_0000, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_busmaster();
        bm_probe("R11", 32'h0000_1000, 2'd1, 32'h0000_1000);
        bm_probe("R11", 32'h3EFF_FFFF, 2'd1, 32'h3EFF_FFFF);
        bm_probe("R11", 32'h3F00_0000, 2'd0, 32'h0);
        bm_probe("R12", 32'h8000_0000, 2'd2, 32'h0);
        bm_probe("R12", 32'hFFFF_FFFC, 2'd2, 32'h7FFF_FFFC);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        t_reset();
        t_config();
        t_io_modes();
        t_lanes();
        t_miss();
        t_busmaster();
        done = 1;
        summary();
        $finish;
    end
endmodule